// File: doc/BRIEF.md
# Dual-Mode Paired General-Purpose Register File

This block is the general-purpose register file of a 16-bit RISC core. It holds sixteen registers: the twelve lowest are 16 bits wide and the four highest are 32 bits wide. Every register can be reached as a plain 16-bit operand. A 32-bit operand is formed either by joining two neighbouring registers or by taking one wide register whole.

A mode input picks the pairing rule. In short-register mode, the two lowest wide registers act as 16-bit halves inside pairs, which keeps older software working. In native mode, the four wide registers are addressed as full 32-bit registers. The file has two combinational read ports and one write port that updates on the clock edge. Each port takes a 4-bit register index and a select bit that chooses between a single access and a pair access.

Top module: `gpr_pair_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every register, including both halves of the wide registers, to zero.
- R2: A single access (`*_pair`=0) at index k reads the low 16 bits of register k on data bits [15:0], with bits [31:16] zero. Indices 0..13 select R0..R13, 14 selects RA and 15 selects SP.
- R3: A single write to a wide register (index 12..15) changes only its low 16 bits and leaves its upper 16 bits unchanged.
- R4: In either mode, a pair access at index n from 0 to 11 reads {low16(register n+1), low16(register n)}. At n=11 the upper half is the low half of R12.
- R5: In short mode (`short_mode`=1), a pair access at index 12 or 13 reads {low16(register n+1), low16(register n)}.
- R6: In short mode, a pair access at index 15 reads and writes SP as one full 32-bit register.
- R7: In native mode (`short_mode`=0), a pair access at index 12, 13, 14 or 15 reads and writes that register's full 32 bits.
- R8: In short mode, a pair access at index 14 reads zero, and a pair write there changes no register.
- R9: A pair write updates both of its halves on the same clock edge. Upper bits of a wide register that lie outside the pair keep their value.
- R10: Reads are combinational and never bypass a write. In the cycle of a write, a read of the target returns the value the register held before that write.
- R11: The two read ports work independently, each with its own index and pair select, and both observe the same stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset take effect on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| short_mode | input | 1 | 1 selects the short-register pairing, 0 selects native pairing |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_pair | input | 1 | Read port A: 1 for a 32-bit access, 0 for a 16-bit access |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_pair | input | 1 | Read port B: 1 for a 32-bit access, 0 for a 16-bit access |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_pair | input | 1 | Write: 1 for a 32-bit access, 0 for a 16-bit access |
| wr_data | input | 32 | Write data; only bits [15:0] are used by a single write |

## Verification
The assertions assume that `short_mode` is the same for reads and writes within a cycle and that every control input has a known value after reset. Writes are checked one edge later against the indexed register state. The bench meets these assumptions by driving all inputs on the falling edge and by changing the mode only in cycles with no write. It sweeps every index, access width and mode, first for writes and then for reads on both ports, and compares each read with a shadow model built from the pairing rules.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  // How one port access resolves onto the physical storage
  typedef enum logic [1:0] {
    ACC_SINGLE = 2'd0,  // low half of one register
    ACC_PAIR   = 2'd1,  // low halves of two neighbouring registers
    ACC_WIDE   = 2'd2,  // full 32 bits of one wide register
    ACC_NONE   = 2'd3   // undefined pair: reads zero, writes dropped
  } acc_kind_e;
endpackage

// File: rtl/gpr_pair_map.sv
module gpr_pair_map
  import gpr_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int WIDE_BASE = 12,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             pair,
  input  logic             short_mode,
  output acc_kind_e        kind,
  output logic [IDX_W-1:0] lo_idx,
  output logic [IDX_W-1:0] hi_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);
  localparam logic [IDX_W-1:0] GAP_IDX  = IDX_W'(NUM_REGS - 2);
  localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(WIDE_BASE);

  always_comb begin
    lo_idx = idx;
    hi_idx = idx + IDX_W'(1);
    kind   = ACC_SINGLE;
    if (pair) begin
      if (idx < BASE_IDX)      kind = ACC_PAIR;
      else if (!short_mode)    kind = ACC_WIDE;
      else if (idx == LAST_IDX) kind = ACC_WIDE;
      else if (idx == GAP_IDX)  kind = ACC_NONE;
      else                      kind = ACC_PAIR;
    end
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int WIDE_BASE = 12,
  parameter int HALF_W    = 16,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [HALF_W-1:0]   lo_q [NUM_REGS],
  input  logic [HALF_W-1:0]   hi_q [NUM_REGS],
  input  logic                short_mode,
  input  logic [IDX_W-1:0]    idx,
  input  logic                pair,
  output logic [2*HALF_W-1:0] data
);
  acc_kind_e        kind;
  logic [IDX_W-1:0] lo_idx, hi_idx;

  gpr_pair_map #(.NUM_REGS(NUM_REGS), .WIDE_BASE(WIDE_BASE)) u_map (
    .idx(idx), .pair(pair), .short_mode(short_mode),
    .kind(kind), .lo_idx(lo_idx), .hi_idx(hi_idx)
  );

  always_comb begin
    unique case (kind)
      ACC_SINGLE: data = {{HALF_W{1'b0}}, lo_q[lo_idx]};
      ACC_PAIR:   data = {lo_q[hi_idx], lo_q[lo_idx]};
      ACC_WIDE:   data = {hi_q[lo_idx], lo_q[lo_idx]};
      default:    data = '0;
    endcase
  end
endmodule

// File: rtl/gpr_write_ctrl.sv
module gpr_write_ctrl
  import gpr_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int WIDE_BASE = 12,
  parameter int HALF_W    = 16,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int NUM_WIDE = NUM_REGS - WIDE_BASE
) (
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_pair,
  input  logic                short_mode,
  input  logic [2*HALF_W-1:0] wr_data,
  output logic [NUM_REGS-1:0] lo_we,
  output logic [HALF_W-1:0]   lo_wd [NUM_REGS],
  output logic [NUM_WIDE-1:0] hi_we
);
  acc_kind_e        kind;
  logic [IDX_W-1:0] lo_idx, hi_idx;

  gpr_pair_map #(.NUM_REGS(NUM_REGS), .WIDE_BASE(WIDE_BASE)) u_map (
    .idx(wr_idx), .pair(wr_pair), .short_mode(short_mode),
    .kind(kind), .lo_idx(lo_idx), .hi_idx(hi_idx)
  );

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      lo_we[r] = wr_en && (((kind != ACC_NONE) && (lo_idx == IDX_W'(r))) ||
                           ((kind == ACC_PAIR) && (hi_idx == IDX_W'(r))));
      lo_wd[r] = ((kind == ACC_PAIR) && (hi_idx == IDX_W'(r))) ?
                 wr_data[2*HALF_W-1:HALF_W] : wr_data[HALF_W-1:0];
    end
    for (int w = 0; w < NUM_WIDE; w++) begin
      hi_we[w] = wr_en && (kind == ACC_WIDE) && (lo_idx == IDX_W'(w + WIDE_BASE));
    end
  end
endmodule

// File: rtl/gpr_pair_file.sv
module gpr_pair_file
  import gpr_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int WIDE_BASE = 12,
  parameter int HALF_W    = 16,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int NUM_WIDE = NUM_REGS - WIDE_BASE,
  localparam int WORD_W   = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              short_mode,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic              rd_a_pair,
  output logic [WORD_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  input  logic              rd_b_pair,
  output logic [WORD_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_pair,
  input  logic [WORD_W-1:0] wr_data
);
  logic [HALF_W-1:0]   lo_q  [NUM_REGS];
  logic [HALF_W-1:0]   hi_q  [NUM_REGS];
  logic [HALF_W-1:0]   lo_wd [NUM_REGS];
  logic [NUM_REGS-1:0] lo_we;
  logic [NUM_WIDE-1:0] hi_we;

  gpr_write_ctrl #(.NUM_REGS(NUM_REGS), .WIDE_BASE(WIDE_BASE), .HALF_W(HALF_W)) u_wctl (
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_pair(wr_pair), .short_mode(short_mode),
    .wr_data(wr_data), .lo_we(lo_we), .lo_wd(lo_wd), .hi_we(hi_we)
  );

  // Storage: low halves for all registers, upper halves only for wide ones
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)           lo_q[g] <= '0;
      else if (lo_we[g]) lo_q[g] <= lo_wd[g];
    end
    if (g >= WIDE_BASE) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst)                     hi_q[g] <= '0;
        else if (hi_we[g-WIDE_BASE]) hi_q[g] <= wr_data[WORD_W-1:HALF_W];
      end
    end else begin : g_narrow
      assign hi_q[g] = '0;
    end
  end

  gpr_read_port #(.NUM_REGS(NUM_REGS), .WIDE_BASE(WIDE_BASE), .HALF_W(HALF_W)) u_rd_a (
    .lo_q(lo_q), .hi_q(hi_q), .short_mode(short_mode),
    .idx(rd_a_idx), .pair(rd_a_pair), .data(rd_a_data)
  );

  gpr_read_port #(.NUM_REGS(NUM_REGS), .WIDE_BASE(WIDE_BASE), .HALF_W(HALF_W)) u_rd_b (
    .lo_q(lo_q), .hi_q(hi_q), .short_mode(short_mode),
    .idx(rd_b_idx), .pair(rd_b_pair), .data(rd_b_data)
  );

  localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(WIDE_BASE);
  localparam logic [IDX_W-1:0] GAP_IDX  = IDX_W'(NUM_REGS - 2);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (lo_q[0] == '0) && (hi_q[NUM_REGS-1] == '0)); // R1

  AST_SINGLE_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    !rd_a_pair |-> (rd_a_data[WORD_W-1:HALF_W] == '0)); // R2

  AST_SINGLE_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_pair && (wr_idx >= BASE_IDX)) |=>
      (hi_q[$past(wr_idx)] == $past(hi_q[wr_idx]))); // R3

  AST_PAIR_BOTH_HALVES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_pair && (wr_idx < BASE_IDX)) |=>
      (lo_q[$past(wr_idx)] == $past(wr_data[HALF_W-1:0])) &&
      (lo_q[$past(wr_idx) + IDX_W'(1)] == $past(wr_data[WORD_W-1:HALF_W]))); // R9

  AST_GAP_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (short_mode && rd_b_pair && (rd_b_idx == GAP_IDX)) |-> (rd_b_data == '0)); // R8

  AST_GAP_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_pair && short_mode && (wr_idx == GAP_IDX)) |=>
      $stable(lo_q[NUM_REGS-2]) && $stable(hi_q[NUM_REGS-2])); // R8

  AST_NATIVE_WIDE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_pair && !short_mode && (wr_idx >= BASE_IDX)) |=>
      ({hi_q[$past(wr_idx)], lo_q[$past(wr_idx)]} == $past(wr_data))); // R7
endmodule

// File: tb/gpr_pair_file_test.sv
module gpr_pair_file_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        short_mode = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic        rd_a_pair = 1'b0, rd_b_pair = 1'b0, wr_en = 1'b0, wr_pair = 1'b0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;

  int checks = 0;
  int errors = 0;

  // Shadow model: low halves and upper halves of every register
  logic [15:0] m_lo [16];
  logic [15:0] m_hi [16];

  always #10ns clk = ~clk;  // 50 MHz

  gpr_pair_file uut (
    .clk(clk), .rst(rst), .short_mode(short_mode),
    .rd_a_idx(rd_a_idx), .rd_a_pair(rd_a_pair), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_pair(rd_b_pair), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_pair(wr_pair), .wr_data(wr_data)
  );

  function automatic logic [31:0] expect_rd(int idx, bit pr, bit sm);
    if (!pr) return {16'h0, m_lo[idx]};                       // R2
    if (idx <= 11) return {m_lo[idx+1], m_lo[idx]};           // R4
    if (!sm) return {m_hi[idx], m_lo[idx]};                   // R7
    if (idx == 15) return {m_hi[15], m_lo[15]};               // R6
    if (idx == 14) return 32'h0;                              // R8
    return {m_lo[idx+1], m_lo[idx]};                          // R5
  endfunction

  function automatic string tag_of(int idx, bit pr, bit sm);
    if (!pr) return "R2";
    if (idx <= 11) return "R4";
    if (!sm) return "R7";
    if (idx == 15) return "R6";
    if (idx == 14) return "R8";
    return "R5";
  endfunction

  task automatic model_write(int idx, bit pr, bit sm, logic [31:0] d);
    if (!pr) m_lo[idx] = d[15:0];                             // R3: upper kept
    else if (idx <= 11 || (sm && idx <= 13)) begin            // R9
      m_lo[idx] = d[15:0]; m_lo[idx+1] = d[31:16];
    end else if (!sm || idx == 15) begin
      m_lo[idx] = d[15:0]; m_hi[idx] = d[31:16];
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Read every target on both ports in both modes (no write in flight)
  task automatic sweep_reads(string ctx);
    for (int sm = 0; sm < 2; sm++)
      for (int i = 0; i < 16; i++)
        for (int p = 0; p < 2; p++) begin
          short_mode = sm[0];
          rd_a_idx = 4'(i);      rd_a_pair = p[0];
          rd_b_idx = 4'(15 - i); rd_b_pair = p[0];
          #1ns;
          check(tag_of(i, p[0], sm[0]), rd_a_data, expect_rd(i, p[0], sm[0]),
                $sformatf("%s port A idx %0d pair %0d mode %0d", ctx, i, p, sm));
          check("R11", rd_b_data, expect_rd(15 - i, p[0], sm[0]),
                $sformatf("%s port B idx %0d pair %0d mode %0d", ctx, 15 - i, p, sm));
        end
  endtask

  task automatic do_write(int idx, bit pr, bit sm, logic [31:0] d);
    @(negedge clk);
    short_mode = sm; wr_en = 1'b1; wr_idx = 4'(idx); wr_pair = pr; wr_data = d;
    rd_a_idx = 4'(idx); rd_a_pair = pr;
    #1ns;
    check("R10", rd_a_data, expect_rd(idx, pr, sm), "read during write cycle");
    @(posedge clk);
    model_write(idx, pr, sm, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] val;
    for (int r = 0; r < 16; r++) begin m_lo[r] = '0; m_hi[r] = '0; end
    // Load non-zero contents, then reset must clear them (R1)
    rst = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_pair = 1'b1; short_mode = 1'b0; wr_idx = 4'd15; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_en = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1ns;
    sweep_reads("R1 after reset");

    // Directed: single write keeps upper half (R3)
    do_write(12, 1'b1, 1'b0, 32'hA5A5_5A5A);
    do_write(12, 1'b0, 1'b0, 32'hFFFF_1234);
    short_mode = 1'b0; rd_a_idx = 4'd12; rd_a_pair = 1'b1; #1ns;
    check("R3", rd_a_data, 32'hA5A5_1234, "single write to wide register");
    // Short-mode pair write keeps upper bits of wide halves (R9)
    do_write(13, 1'b1, 1'b0, 32'h7777_8888);
    do_write(12, 1'b1, 1'b1, 32'hBEEF_CAFE);
    short_mode = 1'b0; rd_a_idx = 4'd12; rd_a_pair = 1'b1;
    rd_b_idx = 4'd13; rd_b_pair = 1'b1; #1ns;
    check("R9", rd_a_data, 32'hA5A5_CAFE, "pair write keeps R12 upper");
    check("R9", rd_b_data, 32'h7777_BEEF, "pair write keeps R13 upper");
    // Undefined pair write ignored (R8)
    do_write(14, 1'b1, 1'b0, 32'h1111_2222);
    do_write(14, 1'b1, 1'b1, 32'h3333_4444);
    short_mode = 1'b0; rd_a_idx = 4'd14; rd_a_pair = 1'b1; #1ns;
    check("R8", rd_a_data, 32'h1111_2222, "short-mode pair 14 write dropped");

    // Exhaustive: every write target, then every read target
    for (int sm = 0; sm < 2; sm++)
      for (int i = 0; i < 16; i++)
        for (int p = 0; p < 2; p++) begin
          val = 32'h9E37_79B9 * 32'(sm * 32 + i * 2 + p + 1);
          do_write(i, p[0], sm[0], val);
          sweep_reads($sformatf("after write idx %0d pair %0d mode %0d", i, p, sm));
        end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule